// File: doc/BRIEF.md
# Scattered-Map Interrupt Controller

This block gathers up to 64 active-low interrupt lines into one request to the processor. Its state sits in two 32-bit register pairs: one pair holds enables, the other holds latched requests. Each pair has a high word and a low word. The source numbers do not map to register bits in a simple way. Each source lands on a fixed word and bit given by a scattered mapping, so software must use that mapping when it enables or acknowledges a source.

Most sources are level-sensitive and active low. Two groups can be set to other detection modes through a detection-mode register. External lines 19 to 25 can use falling-edge or level-low detection. Lines 48 to 63 can use falling-edge or any-edge detection. A vector word reports the most urgent pending, enabled source. Software reads the vector, services that source and acknowledges it by writing a one to its request bit. Every input passes through a two-stage synchronizer before detection.

Top module: `irq_scatter_ctrl`

## Requirements
- R1: The register addresses are: 0 enable high, 1 enable low, 2 request high, 3 request low, 4 detection mode, 5 vector. After reset all of them read zero and `irq_o` is low.
- R2: Source s maps to the low word (addresses 1/3) when s/16 is even, and to the high word (addresses 0/2) otherwise. The bit is found by range:
  - s=0 uses bit 0.
  - s=1..15 uses bit 16−s.
  - s=16..18 uses bit 18−s.
  - s=19..30 uses bit 33−s.
  - s=31 uses bit 0.
  - s=32..47 uses bit 63−s.
  - s=48..63 uses bit s−32.
- R3: An enable bit of 1 lets its request drive `irq_o` and the vector. A request bit still latches while its enable bit is 0. With all enable bits 0, `irq_o` stays low.
- R4: Writing 1 to a request bit clears it. Writing 0 leaves it unchanged.
- R5: The vector word holds the lowest-numbered pending, enabled source in bits [31:26], and zeros in bits [25:0]. It reads 0 when nothing is pending and enabled. `irq_o` is high exactly when the vector is nonzero.
- R6: A source outside the two programmable groups sets its request bit while its line is low. The bit stays set after the line returns high.
- R7: Sources 19..25 use detection-mode bit 33−s. A value of 1 selects falling-edge detection. A value of 0 selects level-low detection.
- R8: Sources 48..63 use detection-mode bit s−32. A value of 1 selects falling-edge detection. A value of 0 selects detection on both edges.
- R9: Only detection-mode bits 31:16 and 14:8 are writable. All other bits read 0, so writing all ones reads back 0xFFFF7F00.
- R10: If a detection event and a write-one clear hit the same request bit in the same cycle, the bit stays set.
- R11: Source 0 is reserved. Its line never sets a request bit.
- R12: A change on a source line that is driven before rising edge 1 shows in the request registers after rising edge 3, and not after rising edge 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| src_n_i | input | 64 | Active-low interrupt lines, one per source number |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Request to the processor |

## Verification
The bench changes a source line at a falling clock edge. Request bits, `irq_o` and the vector then respond after the third rising edge, because of the two synchronizer stages and the request register. The bench therefore waits three rising edges and samples on the next falling edge. The latency test samples one edge early to confirm nothing has moved yet. A register write takes effect at the single rising edge between two falling edges, and the readback is combinational. For the same-cycle race, the clear strobe is placed on exactly the edge where the edge event lands.

// File: rtl/irqsc_pkg.sv
// Package: shared constants, types and the source-to-register mapping.
// Assumes 64 sources over two 32-bit words; word index 0 is "high", 1 is "low".
package irqsc_pkg;
    localparam int NSRC    = 64;
    localparam int WORD_W  = 32;
    localparam int NWORD   = 2;
    localparam int FLAT_W  = NWORD * WORD_W;
    localparam int SRC_W   = $clog2(NSRC);
    localparam int VEC_LSB = WORD_W - SRC_W;
    localparam int EXT_LO  = 19;
    localparam int EXT_HI  = 25;
    localparam int PC_LO   = 48;
    localparam int PC_HI   = 63;

    typedef enum logic [1:0] {
        DET_LEVEL = 2'd0,
        DET_FALL  = 2'd1,
        DET_ANY   = 2'd2
    } det_mode_e;

    typedef enum logic [2:0] {
        RA_EN_HI   = 3'd0,
        RA_EN_LO   = 3'd1,
        RA_REQ_HI  = 3'd2,
        RA_REQ_LO  = 3'd3,
        RA_DETMODE = 3'd4,
        RA_VECTOR  = 3'd5
    } reg_addr_e;

    // Word index of a source: 1 (low) for blocks 0 and 2 of sixteen, else 0 (high).
    function automatic int src_word(input int s);
        return (((s / 16) % 2) == 0) ? 1 : 0;
    endfunction

    // Bit position of a source inside its word (scattered, non-arithmetic).
    function automatic int src_bit(input int s);
        if (s == 0)       return 0;
        else if (s <= 15) return 16 - s;
        else if (s <= 18) return 18 - s;
        else if (s <= 30) return 33 - s;
        else if (s == 31) return 0;
        else if (s <= 47) return 63 - s;
        else              return s - 32;
    endfunction

    // Index into the flattened {low, high} state vector.
    function automatic int flat_idx(input int s);
        return src_word(s) * WORD_W + src_bit(s);
    endfunction

    // Detection-mode bit that a programmable source uses.
    function automatic int det_bit(input int s);
        if (s >= EXT_LO && s <= EXT_HI) return 14 - (s - EXT_LO);
        else                            return WORD_W - 1 - (PC_HI - s);
    endfunction

    // Mask of detection-mode bits that belong to some programmable source.
    function automatic logic [WORD_W-1:0] det_valid_mask();
        logic [WORD_W-1:0] m;
        m = '0;
        for (int s = EXT_LO; s <= EXT_HI; s++) m[det_bit(s)] = 1'b1;
        for (int s = PC_LO; s <= PC_HI; s++)   m[det_bit(s)] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/irqsc_detect.sv
// Per-source synchronizer and event detector.
// Each active-low line passes two flops, then an edge register. The event
// output follows the mode given per source. Flops reset to the idle-high level.
// Source 0 is reserved: it has no flops and never produces an event.
module irqsc_detect
    import irqsc_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N-1:0]      src_n_i,
    input  logic [N-1:0][1:0] mode_i,
    output logic [N-1:0]      event_o
);
    for (genvar g = 0; g < N; g++) begin : g_src
        if (g == 0) begin : g_reserved
            logic unused_src0;
            logic [1:0] unused_mode0;
            assign unused_src0  = src_n_i[g];
            assign unused_mode0 = mode_i[g];
            assign event_o[g]   = 1'b0;
        end else begin : g_live
            logic s1_q, s2_q, prev_q;

            // Synchronize the line and keep the previous synchronized level.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    s1_q   <= 1'b1;
                    s2_q   <= 1'b1;
                    prev_q <= 1'b1;
                end else begin
                    s1_q   <= src_n_i[g];
                    s2_q   <= s1_q;
                    prev_q <= s2_q;
                end
            end

            // Turn the synchronized level into an event for the selected mode.
            always_comb begin
                case (det_mode_e'(mode_i[g]))
                    DET_LEVEL: event_o[g] = ~s2_q;
                    DET_FALL:  event_o[g] = prev_q & ~s2_q;
                    DET_ANY:   event_o[g] = prev_q ^ s2_q;
                    default:   event_o[g] = 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/irqsc_regs.sv
// Register file: enable words, request words and the detection-mode word.
// Also holds the read multiplexer. Request bits are set by event pulses and
// cleared by writing ones. When set and clear hit the same bit, set wins.
// Assumes flat state index = word*WORD_W + bit, with word 0 = high.
module irqsc_regs
    import irqsc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [2:0]        addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [FLAT_W-1:0] set_i,
    input  logic [SRC_W-1:0]  vec_i,
    output logic [FLAT_W-1:0] en_o,
    output logic [FLAT_W-1:0] req_o,
    output logic [WORD_W-1:0] det_o,
    output logic [WORD_W-1:0] rdata_o
);
    localparam logic [WORD_W-1:0] DET_MASK = det_valid_mask();

    logic [FLAT_W-1:0] clr;

    // Decode write-one-to-clear strobes for the two request words.
    always_comb begin
        clr = '0;
        if (wr_en_i && reg_addr_e'(addr_i) == RA_REQ_HI) clr[WORD_W-1:0]      = wdata_i;
        if (wr_en_i && reg_addr_e'(addr_i) == RA_REQ_LO) clr[FLAT_W-1:WORD_W] = wdata_i;
    end

    // Request state: keep uncleared bits, then merge new events.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) req_o <= '0;
        else         req_o <= (req_o & ~clr) | set_i;
    end

    // Enable words and the detection-mode word, written directly.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            en_o  <= '0;
            det_o <= '0;
        end else if (wr_en_i) begin
            case (reg_addr_e'(addr_i))
                RA_EN_HI:   en_o[WORD_W-1:0]      <= wdata_i;
                RA_EN_LO:   en_o[FLAT_W-1:WORD_W] <= wdata_i;
                RA_DETMODE: det_o                 <= wdata_i & DET_MASK;
                default:    ;
            endcase
        end
    end

    // Read multiplexer; the vector sits in the top bits of its word.
    always_comb begin
        case (reg_addr_e'(addr_i))
            RA_EN_HI:   rdata_o = en_o[WORD_W-1:0];
            RA_EN_LO:   rdata_o = en_o[FLAT_W-1:WORD_W];
            RA_REQ_HI:  rdata_o = req_o[WORD_W-1:0];
            RA_REQ_LO:  rdata_o = req_o[FLAT_W-1:WORD_W];
            RA_DETMODE: rdata_o = det_o;
            RA_VECTOR:  rdata_o = {vec_i, {VEC_LSB{1'b0}}};
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irqsc_prio.sv
// Fixed-priority encoder: returns the lowest set index among N sources.
// Index 0 doubles as "none", so the caller must keep act_i[0] low.
module irqsc_prio
    import irqsc_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0]     act_i,
    output logic [SRC_W-1:0] vec_o
);
    // Scan from the top so that the lowest active index is written last.
    always_comb begin
        vec_o = '0;
        for (int s = N - 1; s >= 0; s--) begin
            if (act_i[s]) vec_o = SRC_W'(s);
        end
    end
endmodule

// File: rtl/irq_scatter_ctrl.sv
// Top level: 64-source interrupt controller with a scattered register map.
// Assumes active-low idle-high source lines. The mapping tables are computed
// by functions in irqsc_pkg; the generated wiring follows that mapping.
module irq_scatter_ctrl
    import irqsc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NSRC-1:0]   src_n_i,
    input  logic              wr_en_i,
    input  logic [2:0]        addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              irq_o
);
    logic [NSRC-1:0][1:0] mode;
    logic [NSRC-1:0]      src_event;
    logic [NSRC-1:0]      active;
    logic [FLAT_W-1:0]    set_flat;
    logic [FLAT_W-1:0]    en_q;
    logic [FLAT_W-1:0]    req_q;
    logic [WORD_W-1:0]    det_q;
    logic [SRC_W-1:0]     vec;

    // Pick each source's detection mode from its group and mode bit.
    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            if (s >= EXT_LO && s <= EXT_HI)
                mode[s] = det_q[det_bit(s)] ? DET_FALL : DET_LEVEL;
            else if (s >= PC_LO && s <= PC_HI)
                mode[s] = det_q[det_bit(s)] ? DET_FALL : DET_ANY;
            else
                mode[s] = DET_LEVEL;
        end
    end

    irqsc_detect #(.N(NSRC)) i_detect (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .src_n_i (src_n_i),
        .mode_i  (mode),
        .event_o (src_event)
    );

    // Scatter source events onto register bits (shared bits are ORed).
    always_comb begin
        set_flat = '0;
        for (int s = 1; s < NSRC; s++) begin
            set_flat[flat_idx(s)] = set_flat[flat_idx(s)] | src_event[s];
        end
    end

    irqsc_regs i_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .set_i   (set_flat),
        .vec_i   (vec),
        .en_o    (en_q),
        .req_o   (req_q),
        .det_o   (det_q),
        .rdata_o (rdata_o)
    );

    // Gather pending-and-enabled state back per source number.
    always_comb begin
        active = '0;
        for (int s = 1; s < NSRC; s++) begin
            active[s] = req_q[flat_idx(s)] & en_q[flat_idx(s)];
        end
    end

    irqsc_prio #(.N(NSRC)) i_prio (
        .act_i (active),
        .vec_o (vec)
    );

    // Processor request: any pending bit whose enable is set.
    assign irq_o = |(req_q & en_q);
endmodule

// File: rtl/irqsc_checker.sv
// Checker bound to irq_scatter_ctrl: temporal properties on the register state.
module irqsc_checker
    import irqsc_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [2:0]        addr_i,
    input logic              irq_o,
    input logic [SRC_W-1:0]  vec,
    input logic [FLAT_W-1:0] req_q,
    input logic [FLAT_W-1:0] en_q,
    input logic [FLAT_W-1:0] set_flat
);
    p_reset_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!rst_ni) |-> (req_q == '0 && en_q == '0 && !irq_o));

    p_mask_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_q == '0) |-> !irq_o);

    p_hi_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(wr_en_i && addr_i == RA_REQ_HI) |->
        (($past(req_q[WORD_W-1:0]) & ~req_q[WORD_W-1:0]) == '0));

    p_lo_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(wr_en_i && addr_i == RA_REQ_LO) |->
        (($past(req_q[FLAT_W-1:WORD_W]) & ~req_q[FLAT_W-1:WORD_W]) == '0));

    p_vec_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == (vec != '0));

    p_set_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((req_q & ~$past(req_q) & ~$past(set_flat)) == '0));

    p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (($past(set_flat) & ~req_q) == '0));
endmodule

bind irq_scatter_ctrl irqsc_checker i_irqsc_checker (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .irq_o    (irq_o),
    .vec      (vec),
    .req_q    (req_q),
    .en_q     (en_q),
    .set_flat (set_flat)
);

// File: tb/test_irq_scatter_ctrl.sv
`timescale 1ns/1ps
module test_irq_scatter_ctrl;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [63:0] src_n_i = '1;
    logic        wr_en_i = 1'b0;
    logic [2:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk_i = ~clk_i;

    irq_scatter_ctrl i_irq_scatter_ctrl (
        .clk_i(clk_i), .rst_ni(rst_ni), .src_n_i(src_n_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected word (1 = low, 0 = high) and bit, from R2.
    function automatic int e_word(input int s);
        if (s < 16 || (s >= 32 && s < 48)) return 1;
        return 0;
    endfunction
    function automatic int e_bit(input int s);
        if (s == 0 || s == 31) return 0;
        if (s < 16)  return 16 - s;
        if (s < 19)  return 18 - s;
        if (s < 31)  return 33 - s;
        if (s < 48)  return 63 - s;
        return s - 32;
    endfunction

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        addr_i = a;
        #1 v = rdata_o;
    endtask
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk_i);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk_i);
        wr_en_i = 1'b0;
    endtask
    task automatic settle();
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
    endtask
    task automatic drive(input int s, input logic v);
        @(negedge clk_i);
        src_n_i[s] = v;
    endtask
    task automatic clear_all();
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd3, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk_i);
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R1 reset readback", v, 32'h0);
        end
        chk("R1 reset irq", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] hi, lo;
        logic [63:0] e;
        for (int s = 1; s < 64; s++) begin
            drive(s, 1'b0);
            settle();
            rd(3'd2, hi);
            rd(3'd3, lo);
            e = 64'h0;
            e[e_word(s) * 32 + e_bit(s)] = 1'b1;
            chk($sformatf("R2 map src %0d hi", s), hi, e[31:0]);
            chk($sformatf("R2 map src %0d lo", s), lo, e[63:32]);
            drive(s, 1'b1);
            settle();
            clear_all();
        end
    endtask

    task automatic t_level_and_clear();
        logic [31:0] v;
        drive(5, 1'b0);
        settle();
        drive(5, 1'b1);
        settle();
        rd(3'd3, v);
        chk("R6 level sticky after release", v, 32'h0000_0800);
        wr(3'd3, 32'h0);
        rd(3'd3, v);
        chk("R4 write zero keeps", v, 32'h0000_0800);
        wr(3'd3, 32'h0000_0800);
        rd(3'd3, v);
        chk("R4 write one clears", v, 32'h0);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd5, v);
        chk("R5 vector idle", v, 32'h0);
        drive(3, 1'b0);
        src_n_i[50] = 1'b0;
        settle();
        rd(3'd5, v);
        chk("R5 lowest source wins", v, 32'h0C00_0000);
        drive(3, 1'b1);
        src_n_i[50] = 1'b1;
        settle();
        wr(3'd3, 32'h0000_2000);
        rd(3'd5, v);
        chk("R5 next source after ack", v, 32'hC800_0000);
        chk("R5 irq with vector", {31'h0, irq_o}, 32'h1);
        wr(3'd2, 32'h0004_0000);
        rd(3'd5, v);
        chk("R5 vector empty", v, 32'h0);
        chk("R5 irq low", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(3'd1, 32'h0);
        drive(7, 1'b0);
        settle();
        drive(7, 1'b1);
        settle();
        rd(3'd3, v);
        chk("R3 latches while disabled", v, 32'h0000_0200);
        chk("R3 no irq when disabled", {31'h0, irq_o}, 32'h0);
        rd(3'd5, v);
        chk("R3 no vector when disabled", v, 32'h0);
        wr(3'd1, 32'h0000_0200);
        rd(3'd5, v);
        chk("R3 vector after enable", v, 32'h1C00_0000);
        chk("R3 irq after enable", {31'h0, irq_o}, 32'h1);
        clear_all();
        wr(3'd1, 32'hFFFF_FFFF);
    endtask

    task automatic t_ext();
        logic [31:0] v;
        wr(3'd4, 32'h0000_2000);
        drive(20, 1'b0);
        settle();
        rd(3'd2, v);
        chk("R7 falling edge sets", v, 32'h0000_2000);
        wr(3'd2, 32'h0000_2000);
        settle();
        rd(3'd2, v);
        chk("R7 held low no re-set in edge mode", v, 32'h0);
        drive(20, 1'b1);
        settle();
        rd(3'd2, v);
        chk("R7 rising ignored", v, 32'h0);
        wr(3'd4, 32'h0);
        drive(20, 1'b0);
        settle();
        wr(3'd2, 32'h0000_2000);
        rd(3'd2, v);
        chk("R7 level mode reasserts", v, 32'h0000_2000);
        drive(20, 1'b1);
        settle();
        clear_all();
    endtask

    task automatic t_portc();
        logic [31:0] v;
        drive(60, 1'b0);
        settle();
        wr(3'd2, 32'h1000_0000);
        drive(60, 1'b1);
        settle();
        rd(3'd2, v);
        chk("R8 both-edge mode rising sets", v, 32'h1000_0000);
        wr(3'd2, 32'h1000_0000);
        wr(3'd4, 32'h1000_0000);
        drive(60, 1'b0);
        settle();
        rd(3'd2, v);
        chk("R8 falling mode sets", v, 32'h1000_0000);
        wr(3'd2, 32'h1000_0000);
        drive(60, 1'b1);
        settle();
        rd(3'd2, v);
        chk("R8 falling mode ignores rise", v, 32'h0);
        wr(3'd4, 32'h0);
    endtask

    task automatic t_detmode_rw();
        logic [31:0] v;
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, v);
        chk("R9 writable mode bits", v, 32'hFFFF_7F00);
        wr(3'd4, 32'h0);
        rd(3'd4, v);
        chk("R9 mode cleared", v, 32'h0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        drive(9, 1'b0);
        settle();
        wr(3'd3, 32'h0000_0080);
        rd(3'd3, v);
        chk("R10 level set beats clear", v, 32'h0000_0080);
        drive(9, 1'b1);
        settle();
        clear_all();
        @(negedge clk_i);
        src_n_i[60] = 1'b0;
        @(posedge clk_i);
        @(posedge clk_i);
        @(negedge clk_i);
        wr_en_i = 1'b1; addr_i = 3'd2; wdata_i = 32'h1000_0000;
        @(negedge clk_i);
        wr_en_i = 1'b0;
        rd(3'd2, v);
        chk("R10 edge set beats clear", v, 32'h1000_0000);
        drive(60, 1'b1);
        settle();
        clear_all();
    endtask

    task automatic t_src0();
        logic [31:0] v;
        drive(0, 1'b0);
        settle();
        rd(3'd3, v);
        chk("R11 source 0 ignored", v, 32'h0);
        chk("R11 no irq from source 0", {31'h0, irq_o}, 32'h0);
        drive(0, 1'b1);
    endtask

    task automatic t_latency();
        logic [31:0] v;
        @(negedge clk_i);
        src_n_i[9] = 1'b0;
        @(posedge clk_i);
        @(posedge clk_i);
        @(negedge clk_i);
        rd(3'd3, v);
        chk("R12 not after edge 2", v, 32'h0);
        @(posedge clk_i);
        @(negedge clk_i);
        rd(3'd3, v);
        chk("R12 visible after edge 3", v, 32'h0000_0080);
        drive(9, 1'b1);
        settle();
        clear_all();
    endtask

    initial begin
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset();
        t_map();
        t_level_and_clear();
        t_priority();
        t_mask();
        t_ext();
        t_portc();
        t_detmode_rw();
        t_race();
        t_src0();
        t_latency();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule